// File: doc/BRIEF.md
# SPI EEPROM read emulator

This block is an SPI target that answers like a serial EEPROM, but only for reads, and it reads from a constant byte table fixed at elaboration. A host lowers chip select and sends an 8-bit opcode. If that opcode is the read code, the host sends a start address and then clocks out as many bytes as it wants. After each byte the internal address steps by one, so one transaction can read a whole region. Any other opcode leaves the output quiet until the host deselects.

All three SPI inputs are brought into the system clock domain through a synchronizer chain. SCK edges are then found by comparing the synchronized value with the one a cycle earlier. Transfers use mode 0: the host samples MISO on the rising edge of SCK, and the block moves to the next bit on the falling edge. The table has a parameter depth, and every address at or past that depth reads as zero.

Top module: `spi_rom_target`

## Requirements
- R1: After reset, and for as long as chip select is high, MISO is 0 whatever SCK and MOSI do.
- R2: A transaction made of opcode 0x03 (MSB first) and then an 8-bit address (MSB first) returns the table byte at that address MSB first. The first bit is valid on MISO before the first SCK rising edge after the address. Each later bit is valid after the falling edge that follows the previous rising edge.
- R3: When the opcode is anything other than 0x03, MISO stays 0 for the rest of that transaction, through the address phase and any bytes clocked afterwards.
- R4: While chip select stays low after a byte is read, the next byte clocked out comes from the next higher address. Bursts can be of any length.
- R5: Addresses greater than or equal to the table depth read as 0x00. This also applies when a burst moves past the last entry.
- R6: Raising chip select in any phase abandons the transaction. The next transaction starts again from opcode reception.
- R7: MISO is 0 during the opcode and address phases of a read.
- R8: During a burst the address wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it samples all SPI inputs |
| rst_n | input | 1 | Synchronous reset, active low |
| spi_cs_n | input | 1 | Chip select from the host, active low |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |

## Verification
An SCK edge takes effect SYNC_STAGES+1 system clocks after it reaches the pin. Each new data byte is loaded two clocks after the edge that ends the address or the previous byte. To cover this, the bench holds each SCK level for eight system clocks. It samples MISO on the falling clock edge just before it raises SCK, so every due bit has had several clocks to settle. The driver pushes each expected byte into a queue as it clocks that byte. The monitor pops and compares a byte only once the driver has collected all eight of its sampled bits. Opcode and address bits are compared against 0 one by one as they are sent.

// File: rtl/spi_rom_pkg.sv
// Shared types for the SPI read emulator.
// Assumes: nothing beyond IEEE 1800-2017.
package spi_rom_pkg;

    // Transaction phases of the read emulator
    typedef enum logic [2:0] {
        ST_INACTIVE,
        ST_RX_CMD,
        ST_RX_ADDR,
        ST_LOAD,
        ST_SEND,
        ST_NEXT,
        ST_WAIT_END
    } rd_state_e;

    localparam logic [7:0] READ_OPCODE = 8'h03;

endpackage

// File: rtl/spi_rom_sync.sv
// Brings CS_n, SCK and MOSI into the clk domain through a chain of
// STAGES flops each, and flags SCK rising and falling edges for one clock.
// Assumes: the SCK period is well above 2*(STAGES+1) clk periods, and
// STAGES >= 2.
module spi_rom_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic mosi_i,
    output logic cs_n_o,
    output logic mosi_o,
    output logic sck_rise_o,
    output logic sck_fall_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] sck_pipe;
    logic [STAGES-1:0] mosi_pipe;
    logic              sck_prev;

    // Synchronizer chains; reset puts them in the idle state (deselected, SCK low)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_pipe   <= '1;
            sck_pipe  <= '0;
            mosi_pipe <= '0;
            sck_prev  <= 1'b0;
        end else begin
            cs_pipe   <= {cs_pipe[STAGES-2:0], cs_n_i};
            sck_pipe  <= {sck_pipe[STAGES-2:0], sck_i};
            mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi_i};
            sck_prev  <= sck_pipe[LAST];
        end
    end

    // Edge flags from the synchronized SCK
    assign sck_rise_o = sck_pipe[LAST] & ~sck_prev;
    assign sck_fall_o = ~sck_pipe[LAST] & sck_prev;
    assign cs_n_o     = cs_pipe[LAST];
    assign mosi_o     = mosi_pipe[LAST];

endmodule

// File: rtl/spi_rom_store.sv
// Constant byte table. Entry i is ROM_INIT[8*i +: 8]. Addresses at or
// past DEPTH return zero.
// Assumes: 2 <= DEPTH <= 2**ADDR_W.
module spi_rom_store #(
    parameter int                 DEPTH    = 64,
    parameter int                 ADDR_W   = 8,
    parameter logic [8*DEPTH-1:0] ROM_INIT = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        data_o
);
    localparam int              IDX_W = $clog2(DEPTH);
    localparam int              SLOTS = 1 << IDX_W;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(DEPTH);

    logic [7:0] table_q [SLOTS];
    logic       in_range;

    // Fill the power-of-two table; slots past DEPTH are zero
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < DEPTH) begin : g_used
            assign table_q[i] = ROM_INIT[8*i +: 8];
        end else begin : g_pad
            assign table_q[i] = 8'h00;
        end
    end

    // Range check, then lookup
    assign in_range = {1'b0, addr_i} < LIMIT;
    assign data_o   = in_range ? table_q[addr_i[IDX_W-1:0]] : 8'h00;

endmodule

// File: rtl/spi_rom_target.sv
// SPI mode-0 target that imitates a read-only serial EEPROM. It takes an
// 8-bit opcode, and on READ_OP an ADDR_W-bit start address (both MSB
// first). It then streams table bytes MSB first, stepping the address
// after each byte. A deselect resets the transaction.
// Assumes: the host keeps each SCK level for at least SYNC_STAGES+3 clk periods.
module spi_rom_target
    import spi_rom_pkg::*;
#(
    parameter int                     ADDR_W      = 8,
    parameter int                     ROM_DEPTH   = 64,
    parameter int                     SYNC_STAGES = 2,
    parameter logic [7:0]             READ_OP     = READ_OPCODE,
    parameter logic [8*ROM_DEPTH-1:0] ROM_INIT    = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    output logic spi_miso
);
    localparam int             CNT_MAX  = (ADDR_W > 8) ? ADDR_W : 8;
    localparam int             CNT_W    = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(7);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] BYTE_DONE = CNT_W'(8);

    logic              cs_n_s, mosi_s, sck_rise, sck_fall;
    rd_state_e         state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [7:0]        cmd_sr;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_sr;
    logic [7:0]        rom_byte;
    logic [7:0]        cmd_next;

    spi_rom_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (spi_cs_n),
        .sck_i      (spi_sck),
        .mosi_i     (spi_mosi),
        .cs_n_o     (cs_n_s),
        .mosi_o     (mosi_s),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall)
    );

    spi_rom_store #(.DEPTH(ROM_DEPTH), .ADDR_W(ADDR_W), .ROM_INIT(ROM_INIT)) u_store (
        .addr_i (addr_q),
        .data_o (rom_byte)
    );

    // Opcode as it stands once the current MOSI bit has been shifted in
    assign cmd_next = {cmd_sr[6:0], mosi_s};

    // Transaction FSM with its opcode, address and output shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_INACTIVE;
            bit_cnt <= '0;
            cmd_sr  <= '0;
            addr_q  <= '0;
            data_sr <= '0;
        end else if (cs_n_s) begin
            state   <= ST_INACTIVE;
            bit_cnt <= '0;
        end else begin
            case (state)
                ST_INACTIVE: begin
                    state   <= ST_RX_CMD;
                    bit_cnt <= '0;
                end
                ST_RX_CMD: begin
                    if (sck_rise) begin
                        cmd_sr  <= cmd_next;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == CMD_LAST) begin
                            bit_cnt <= '0;
                            state   <= (cmd_next == READ_OP) ? ST_RX_ADDR : ST_WAIT_END;
                        end
                    end
                end
                ST_RX_ADDR: begin
                    if (sck_rise) begin
                        addr_q  <= {addr_q[ADDR_W-2:0], mosi_s};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == ADDR_LAST) begin
                            bit_cnt <= '0;
                            state   <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: begin
                    data_sr <= rom_byte;
                    bit_cnt <= '0;
                    state   <= ST_SEND;
                end
                ST_SEND: begin
                    // Count host samples on rising edges; shift only on a
                    // falling edge that follows a sample of this byte
                    if (sck_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (sck_fall && bit_cnt != '0) begin
                        if (bit_cnt == BYTE_DONE) begin
                            state <= ST_NEXT;
                        end else begin
                            data_sr <= {data_sr[6:0], 1'b0};
                        end
                    end
                end
                ST_NEXT: begin
                    addr_q <= addr_q + 1'b1;
                    state  <= ST_LOAD;
                end
                ST_WAIT_END: begin
                    state <= ST_WAIT_END;
                end
                default: state <= ST_INACTIVE;
            endcase
        end
    end

    // MISO carries data only while a byte is being sent
    assign spi_miso = (state == ST_SEND) & data_sr[7];

    // R6
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (state == ST_INACTIVE));

    // R3
    bad_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_END && !cs_n_s) |=> (state == ST_WAIT_END));

    // R4
    burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NEXT && !cs_n_s) |=> (addr_q == $past(addr_q) + 1'b1));

    // R2
    load_to_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && !cs_n_s) |=> (state == ST_SEND && data_sr == $past(rom_byte)));

endmodule

// File: tb/spi_rom_target_bench.sv
// Scoreboard bench: the driver clocks SPI transactions and queues the
// expected and captured bytes; the monitor pops and compares them.
module spi_rom_target_bench;
    localparam int DEPTH = 40;
    localparam int HALF  = 8;

    function automatic logic [8*DEPTH-1:0] build_rom();
        logic [8*DEPTH-1:0] v;
        v = '0;
        for (int i = 0; i < DEPTH; i++) v[8*i +: 8] = 8'((i * 37 + 5) & 255);
        return v;
    endfunction

    localparam logic [8*DEPTH-1:0] ROM_IMG = build_rom();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_sck = 1'b0;
    logic spi_mosi = 1'b0;
    logic spi_miso;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] exp_q [$];
    logic [7:0] obs_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    spi_rom_target #(.ROM_DEPTH(DEPTH), .ROM_INIT(ROM_IMG)) u_spi_rom_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_cs_n (spi_cs_n),
        .spi_sck  (spi_sck),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso)
    );

    function automatic logic [7:0] rom_at(input int a);
        return (a < DEPTH) ? 8'((a * 37 + 5) & 255) : 8'h00;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One mode-0 bit: set MOSI, sample MISO just before the rising edge
    task automatic spi_bit(input logic mo, output logic mi);
        spi_mosi = mo;
        repeat (HALF) @(negedge clk);
        mi = spi_miso;
        spi_sck = 1'b1;
        repeat (HALF) @(negedge clk);
        spi_sck = 1'b0;
    endtask

    task automatic send_header(input logic [7:0] cmd, input logic [7:0] addr, input string req);
        logic m;
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 7; b >= 0; b--) begin
            spi_bit(cmd[b], m);
            check(m == 1'b0, req, m, 0);
        end
        for (int b = 7; b >= 0; b--) begin
            spi_bit(addr[b], m);
            check(m == 1'b0, req, m, 0);
        end
    endtask

    task automatic deselect();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    // Driver: full transaction; pushes the expected and captured bytes
    task automatic xfer(input logic [7:0] cmd, input logic [7:0] addr, input int nbytes,
                        input string req);
        logic [7:0] cap;
        logic       m;
        bit         is_read;
        is_read = (cmd == 8'h03);
        send_header(cmd, addr, is_read ? "R7" : "R3");
        for (int k = 0; k < nbytes; k++) begin
            exp_q.push_back(is_read ? rom_at(int'(8'(addr + k))) : 8'h00);
            tag_q.push_back(req);
            for (int b = 7; b >= 0; b--) begin
                spi_bit(1'b0, m);
                cap[b] = m;
            end
            obs_q.push_back(cap);
        end
        deselect();
    endtask

    // Monitor: compare each captured byte against its expected value
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] o, e;
                string t;
                o = obs_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(o == e, t, o, e);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic m;
        logic [2:0] part;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: quiet after reset and while deselected
        check(spi_miso == 1'b0, "R1", spi_miso, 0);
        for (int i = 0; i < 16; i++) begin
            spi_bit(i[0], m);
            check(m == 1'b0, "R1", m, 0);
        end
        repeat (4 * HALF) @(negedge clk);

        // R2: single-byte reads
        xfer(8'h03, 8'd0, 1, "R2");
        xfer(8'h03, 8'd17, 1, "R2");
        xfer(8'h03, 8'd39, 1, "R2");
        // R4: burst
        xfer(8'h03, 8'd3, 6, "R4");
        // R5: out of range, and a burst that runs past the end
        xfer(8'h03, 8'd40, 2, "R5");
        xfer(8'h03, 8'd200, 1, "R5");
        xfer(8'h03, 8'd38, 4, "R5");
        // R8: wrap from 255 to 0
        xfer(8'h03, 8'd254, 3, "R8");
        // R3: unknown opcodes stay quiet
        xfer(8'h0B, 8'd5, 2, "R3");
        xfer(8'h02, 8'd1, 2, "R3");
        xfer(8'h83, 8'd2, 1, "R3");

        // R6: abandon a read after three bits, then read fresh
        send_header(8'h03, 8'd10, "R7");
        for (int b = 2; b >= 0; b--) begin
            spi_bit(1'b0, m);
            part[b] = m;
        end
        check(part == rom_at(10)[7:5], "R6", part, rom_at(10)[7:5]);
        deselect();
        check(spi_miso == 1'b0, "R6", spi_miso, 0);
        xfer(8'h03, 8'd11, 1, "R6");
        // R6: abandon during the address phase, then read fresh
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 7; b >= 0; b--) spi_bit(b == 1 || b == 0, m);
        for (int b = 0; b < 3; b++) spi_bit(1'b1, m);
        deselect();
        xfer(8'h03, 8'd20, 2, "R6");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule